// File: doc/BRIEF.md
# Sequential Write Burst Coalescer

This block sits between a kernel that issues single-word writes and a memory write port that accepts bursts. The kernel offers one word address and one data word at a time. While each new address is exactly one more than the previous one, the words are collected into the same burst. A burst is closed by a break in the address sequence, by reaching the maximum burst length, or by a quiet spell with no new write. A closed burst is sent to memory as one address/length command followed by its data beats, and the last beat is flagged.

For every memory acknowledgement the block places one entry in a response queue toward the kernel. That entry holds the burst length minus one, so a single entry can account for many writes. The kernel tracks completion by adding entry plus one to its count of finished writes. The response queue has a fixed depth. While it is full, the block takes no new writes. A kernel that never reads responses therefore stalls the block for good, and this behaviour is intended.

Addresses are word indices: "contiguous" means the new address equals the previous accepted address plus one.

Top module: `wbc_coalescer`

## Requirements
- R1: After synchronous active-low reset, `in_ready` is 1 and `aw_valid`, `w_valid`, `rsp_valid` and `b_ready` are 0.
- R2: Writes whose address is the previous accepted address plus one join the open burst. The burst command carries the first address on `aw_addr` and the beat count minus one on `aw_len`.
- R3: A burst holds at most MAX_BURST (16) beats. When it reaches that count it closes, and `aw_len` never exceeds MAX_BURST-1 (15).
- R4: A write whose address is not the open burst's next address closes the open burst and starts a new one.
- R5: A write accepted up to TIMEOUT (8) cycles after the previous accepted write (accept edges 8 apart) may join its burst. If no write is accepted for TIMEOUT+1 cycles, the burst closes and the next write starts a new one.
- R6: Data beats leave in acceptance order. `w_last` is 1 on exactly the final beat of each burst.
- R7: Each acknowledgement taken on `b_valid`/`b_ready` yields exactly one response entry. Its `rsp_len` equals that burst's beat count minus one, and entries come out in burst order.
- R8: While the response queue holds RSP_DEPTH entries, `in_ready` is 0, and it stays 0 for as long as the kernel does not read.
- R9: A command (`aw_valid`), or a response (`rsp_valid`), that is not accepted stays valid with unchanged content on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Kernel offers a write |
| in_ready | output | 1 | Write accepted this cycle when valid |
| in_addr | input | ADDR_W | Word address of the write |
| in_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response entry available |
| rsp_ready | input | 1 | Kernel takes the response entry |
| rsp_len | output | LEN_W | Burst length minus one |
| aw_valid | output | 1 | Burst command valid |
| aw_ready | input | 1 | Memory takes the command |
| aw_addr | output | ADDR_W | First word address of the burst |
| aw_len | output | LEN_W | Beats in the burst minus one |
| w_valid | output | 1 | Data beat valid |
| w_ready | input | 1 | Memory takes the beat |
| w_data | output | DATA_W | Beat data |
| w_last | output | 1 | Final beat of the burst |
| b_valid | input | 1 | Memory acknowledges one burst |
| b_ready | output | 1 | Block takes the acknowledgement |

## Verification
The bench builds the block with its defaults: MAX_BURST 16, TIMEOUT 8, RSP_DEPTH 4, OUTS_DEPTH 4, LEN_W 8. With a burst cap of 16, a 20-word run shows a full burst followed by a short one. A timeout of 8 lets the bench place writes exactly 8 and 9 cycles apart to probe the merge boundary. A response depth of 4 means four single-word bursts fill the queue, so the permanent stall against a kernel that never reads is reached within a few dozen cycles.

// File: rtl/wbc_pkg.sv
// Shared types of the write burst coalescer.
package wbc_pkg;
    // Phase of the burst gatherer: filling, issuing the command, sending beats.
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_ADDR    = 2'd1,
        ST_DATA    = 2'd2
    } phase_t;
endpackage

// File: rtl/wbc_fifo.sv
// Synchronous FIFO, first-word fall-through.
// Assumes: push is ignored when full, pop is ignored when empty.
module wbc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] used;
    logic          do_push, do_pop;

    assign full    = (used == CW'(DEPTH));
    assign empty   = (used == '0);
    assign dout    = slots[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            if (do_push && !do_pop)      used <= used + CW'(1);
            else if (do_pop && !do_push) used <= used - CW'(1);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= din;
    end
endmodule

// File: rtl/wbc_gather.sv
// Burst gatherer: collects contiguous single-word writes, then issues one
// burst command and streams the stored beats with a final-beat flag.
// Assumes: room gates new writes (response space), issue_ok gates the command
// (outstanding-burst space). Addresses are word indices.
module wbc_gather
    import wbc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MAX_BURST = 16,
    parameter int TIMEOUT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              room,
    input  logic              issue_ok,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [LEN_W-1:0]  aw_len,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [DATA_W-1:0] w_data,
    output logic              w_last
);
    localparam int CW = $clog2(MAX_BURST + 1);
    localparam int BW = $clog2(MAX_BURST);
    localparam int IW = $clog2(TIMEOUT + 1);

    phase_t            phase;
    logic [DATA_W-1:0] store [MAX_BURST];
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     beat;
    logic [ADDR_W-1:0] base, next_addr;
    logic [IW-1:0]     idle;
    logic              contig, accept, close;

    assign contig   = (cnt == '0) || (in_addr == next_addr);
    assign in_ready = (phase == ST_COLLECT) && room &&
                      ((cnt == '0) ||
                       (contig && cnt < CW'(MAX_BURST) && idle < IW'(TIMEOUT)));
    assign accept   = in_valid && in_ready;
    assign close    = (phase == ST_COLLECT) && (cnt != '0) &&
                      (cnt == CW'(MAX_BURST) || idle == IW'(TIMEOUT) ||
                       (in_valid && !contig));

    assign aw_valid = (phase == ST_ADDR) && issue_ok;
    assign aw_addr  = base;
    assign aw_len   = LEN_W'(cnt - CW'(1));
    assign w_valid  = (phase == ST_DATA);
    assign w_data   = store[beat];
    assign w_last   = (CW'(beat) + CW'(1)) == cnt;

    // Phase sequencing, beat count, address tracking and idle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= ST_COLLECT;
            cnt       <= '0;
            beat      <= '0;
            base      <= '0;
            next_addr <= '0;
            idle      <= '0;
        end else begin
            unique case (phase)
                ST_COLLECT: begin
                    if (accept) begin
                        cnt       <= cnt + CW'(1);
                        next_addr <= in_addr + ADDR_W'(1);
                        idle      <= '0;
                        if (cnt == '0) base <= in_addr;
                    end else if (close) begin
                        phase <= ST_ADDR;
                    end else if (cnt != '0 && idle != IW'(TIMEOUT)) begin
                        idle <= idle + IW'(1);
                    end
                end
                ST_ADDR: begin
                    if (aw_valid && aw_ready) begin
                        phase <= ST_DATA;
                        beat  <= '0;
                    end
                end
                ST_DATA: begin
                    if (w_ready) begin
                        if (w_last) begin
                            phase <= ST_COLLECT;
                            cnt   <= '0;
                            idle  <= '0;
                        end else begin
                            beat <= beat + BW'(1);
                        end
                    end
                end
                default: phase <= ST_COLLECT;
            endcase
        end
    end

    // Beat storage write on each accepted word.
    always_ff @(posedge clk) begin
        if (accept) store[BW'(cnt)] <= in_data;
    end
endmodule

// File: rtl/wbc_coalescer.sv
// Write burst coalescer top: gatherer, queue of issued burst lengths, and
// response queue toward the kernel (one entry per acknowledged burst,
// holding length minus one).
// Assumes: memory acknowledges bursts in issue order; MAX_BURST <= 2**LEN_W.
module wbc_coalescer #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int MAX_BURST  = 16,
    parameter int TIMEOUT    = 8,
    parameter int RSP_DEPTH  = 4,
    parameter int OUTS_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [LEN_W-1:0]  rsp_len,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [LEN_W-1:0]  aw_len,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [DATA_W-1:0] w_data,
    output logic              w_last,
    input  logic              b_valid,
    output logic              b_ready
);
    logic             rsp_full, rsp_empty;
    logic             lq_full, lq_empty;
    logic [LEN_W-1:0] lq_head;

    assign b_ready   = !lq_empty && !rsp_full;
    assign rsp_valid = !rsp_empty;

    wbc_gather #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .MAX_BURST(MAX_BURST), .TIMEOUT(TIMEOUT)
    ) u_gather (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data),
        .room(!rsp_full), .issue_ok(!lq_full),
        .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr(aw_addr), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready),
        .w_data(w_data), .w_last(w_last)
    );

    // Lengths of issued bursts awaiting acknowledgement.
    wbc_fifo #(.W(LEN_W), .DEPTH(OUTS_DEPTH)) u_lenq (
        .clk(clk), .rst_n(rst_n),
        .push(aw_valid && aw_ready), .din(aw_len),
        .pop(b_valid && b_ready), .dout(lq_head),
        .full(lq_full), .empty(lq_empty)
    );

    // Responses toward the kernel.
    wbc_fifo #(.W(LEN_W), .DEPTH(RSP_DEPTH)) u_rspq (
        .clk(clk), .rst_n(rst_n),
        .push(b_valid && b_ready), .din(lq_head),
        .pop(rsp_valid && rsp_ready), .dout(rsp_len),
        .full(rsp_full), .empty(rsp_empty)
    );
endmodule

// File: rtl/wbc_coalescer_chk.sv
// Protocol checker for wbc_coalescer, attached by bind. Keeps its own
// counters of handshakes to judge beat position, occupancy and outstanding bursts.
module wbc_coalescer_chk #(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MAX_BURST = 16,
    parameter int RSP_DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [LEN_W-1:0]  rsp_len,
    input logic              aw_valid,
    input logic              aw_ready,
    input logic [ADDR_W-1:0] aw_addr,
    input logic [LEN_W-1:0]  aw_len,
    input logic              w_valid,
    input logic              w_ready,
    input logic              w_last,
    input logic              b_valid,
    input logic              b_ready
);
    logic [LEN_W-1:0] wcnt, wlen;
    logic [15:0]      rocc, outs;
    logic             aw_f, w_f, b_f, r_f;

    assign aw_f = aw_valid && aw_ready;
    assign w_f  = w_valid && w_ready;
    assign b_f  = b_valid && b_ready;
    assign r_f  = rsp_valid && rsp_ready;

    // Track beat position, response occupancy and outstanding bursts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0; wlen <= '0; rocc <= '0; outs <= '0;
        end else begin
            if (aw_f) begin wlen <= aw_len; wcnt <= '0; end
            else if (w_f) wcnt <= wcnt + LEN_W'(1);
            rocc <= rocc + 16'(b_f) - 16'(r_f);
            outs <= outs + 16'(aw_f) - 16'(b_f);
        end
    end

    a_r3_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid |-> (aw_len < LEN_W'(MAX_BURST)));
    a_r6_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
        w_f |-> (w_last == (wcnt == wlen)));
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rocc == 16'(RSP_DEPTH)) |-> !in_ready);
    a_r7_ack_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        b_ready |-> (outs != 16'd0));
    a_r9_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && !aw_ready) |=> (aw_valid && $stable(aw_addr) && $stable(aw_len)));
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_len)));
endmodule

bind wbc_coalescer wbc_coalescer_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .RSP_DEPTH(RSP_DEPTH)
) u_chk (.*);

// File: tb/tb_wbc_coalescer.sv
// Bench: behavioural reference (queues of expected bursts, data and responses)
// compared on every clock just before the active edge.
module tb_wbc_coalescer;
    localparam int AW = 32, DW = 32, LW = 8, MAXB = 16, TMO = 8, RSPD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          in_valid = 0, in_ready, rsp_valid, rsp_ready = 0;
    logic [AW-1:0] in_addr = '0, aw_addr;
    logic [DW-1:0] in_data = '0, w_data;
    logic [LW-1:0] rsp_len, aw_len;
    logic          aw_valid, aw_ready = 0, w_valid, w_ready = 0, w_last;
    logic          b_valid = 0, b_ready;

    wbc_coalescer dut (.*);

    int checks = 0, failures = 0;
    bit done = 0;
    longint cyc = 0;

    // Reference state.
    logic [AW-1:0] ref_bases[$];
    int            ref_lens[$], wlens[$], exp_rsp[$], aw_log[$];
    logic [DW-1:0] ref_data[$];
    bit            op_has = 0;
    logic [AW-1:0] op_base, op_next;
    int            op_len = 0, wb = 0, wcur = 0, bdone = 0, rocc = 0, accepts = 0;
    longint        op_cyc = 0;
    bit            acc_now = 0, hold_pend = 0, jit = 0, rsp_en = 1;
    logic [LW-1:0] hold_len;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Reference: fold one accepted write into the open or a new burst (R2 R3 R4 R5).
    task automatic ref_accept(input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (op_has && a == op_next && op_len < MAXB && (cyc - op_cyc) <= TMO) begin
            op_len++;
        end else begin
            if (op_has) begin ref_bases.push_back(op_base); ref_lens.push_back(op_len); end
            op_has = 1; op_base = a; op_len = 1;
        end
        op_next = a + 1; op_cyc = cyc; ref_data.push_back(d);
        accepts++;
    endtask

    // Reference: compare one burst command.
    task automatic ref_aw();
        logic [AW-1:0] b; int l;
        if (ref_lens.size() != 0) begin b = ref_bases.pop_front(); l = ref_lens.pop_front(); end
        else if (op_has) begin b = op_base; l = op_len; op_has = 0; end
        else begin chk(0, "R2", "unexpected command", longint'(aw_len), -1); return; end
        chk(aw_addr == b, "R2", "aw_addr", longint'(aw_addr), longint'(b));
        chk(int'(aw_len) == l - 1, "R2", "aw_len", longint'(aw_len), l - 1);
        wlens.push_back(l); exp_rsp.push_back(l - 1); aw_log.push_back(int'(aw_len));
    endtask

    // Reference: compare one data beat.
    task automatic ref_w();
        logic [DW-1:0] d;
        if (wb == 0) wcur = (wlens.size() != 0) ? wlens.pop_front() : 0;
        d = (ref_data.size() != 0) ? ref_data.pop_front() : '0;
        chk(w_data == d, "R6", "w_data", longint'(w_data), longint'(d));
        chk(w_last == (wb == wcur - 1), "R6", "w_last", longint'(w_last), longint'(wb == wcur - 1));
        wb++;
        if (wb >= wcur) begin wb = 0; bdone++; end
    endtask

    // Monitor: sample just before each rising edge and compare.
    always begin
        @(negedge clk); #4;
        cyc++;
        acc_now = in_valid && in_ready;
        if (rst_n) begin
            if (rocc == RSPD) chk(!in_ready, "R8", "in_ready with full queue", longint'(in_ready), 0);
            if (hold_pend) begin
                chk(rsp_valid, "R9", "rsp_valid held", longint'(rsp_valid), 1);
                chk(rsp_len == hold_len, "R9", "rsp_len held", longint'(rsp_len), longint'(hold_len));
            end
            hold_pend = rsp_valid && !rsp_ready; hold_len = rsp_len;
            if (acc_now) ref_accept(in_addr, in_data);
            if (aw_valid && aw_ready) ref_aw();
            if (w_valid && w_ready) ref_w();
            if (rsp_valid && rsp_ready) begin
                int e;
                e = (exp_rsp.size() != 0) ? exp_rsp.pop_front() : -1;
                chk(int'(rsp_len) == e, "R7", "rsp_len", longint'(rsp_len), e);
                rocc--;
            end
            if (b_valid && b_ready) begin bdone--; rocc++; end
        end
    end

    // Memory and kernel-response side drivers.
    always @(negedge clk) begin
        aw_ready  <= jit ? ($urandom_range(0, 1) == 1) : 1'b1;
        w_ready   <= jit ? ($urandom_range(0, 2) != 0) : 1'b1;
        b_valid   <= (bdone > 0);
        rsp_ready <= rsp_en && (jit ? ($urandom_range(0, 2) != 0) : 1'b1);
    end

    // Offer one write (called at a falling edge), then idle for gap cycles.
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap);
        in_valid = 1; in_addr = a; in_data = d;
        do @(posedge clk); while (!acc_now);
        @(negedge clk);
        in_valid = 0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain();
        int quiet = 0;
        while (quiet < 20) begin
            @(negedge clk);
            if (op_has || ref_lens.size() != 0 || exp_rsp.size() != 0 || bdone != 0) quiet = 0;
            else quiet++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        logic [AW-1:0] a;
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R1: reset state.
        chk(in_ready == 1, "R1", "in_ready", longint'(in_ready), 1);
        chk(aw_valid == 0, "R1", "aw_valid", longint'(aw_valid), 0);
        chk(w_valid == 0, "R1", "w_valid", longint'(w_valid), 0);
        chk(rsp_valid == 0, "R1", "rsp_valid", longint'(rsp_valid), 0);
        chk(b_ready == 0, "R1", "b_ready", longint'(b_ready), 0);
        @(negedge clk);

        // R2: five contiguous writes make one burst.
        for (int i = 0; i < 5; i++) send(32'd10 + i, 32'hA0 + i, 0);
        drain();
        chk(aw_log.size() == 1 && aw_log[0] == 4, "R2", "burst of 5", aw_log.size(), 1);
        aw_log.delete();

        // R3: twenty contiguous writes split at 16.
        for (int i = 0; i < 20; i++) send(32'd200 + i, 32'hB00 + i, 0);
        drain();
        chk(aw_log.size() == 2 && aw_log[0] == 15 && aw_log[1] == 3, "R3", "16 then 4",
            aw_log.size() > 0 ? aw_log[0] : -1, 15);
        aw_log.delete();

        // R4: address break splits.
        send(32'd40, 32'h1, 0); send(32'd41, 32'h2, 0);
        send(32'd90, 32'h3, 0); send(32'd91, 32'h4, 0);
        drain();
        chk(aw_log.size() == 2 && aw_log[0] == 1 && aw_log[1] == 1, "R4", "two bursts of 2",
            aw_log.size(), 2);
        aw_log.delete();

        // R5: accept edges 8 apart merge, 9 apart split.
        send(32'd50, 32'h50, 7); send(32'd51, 32'h51, 8); send(32'd52, 32'h52, 0);
        drain();
        chk(aw_log.size() == 2 && aw_log[0] == 1 && aw_log[1] == 0, "R5", "timeout boundary",
            aw_log.size() > 0 ? aw_log[0] : -1, 1);
        aw_log.delete();

        // R8: kernel never reads; queue fills and writes stall.
        rsp_en = 0;
        for (int i = 0; i < 4; i++) send(32'd1000 * (i + 1), 32'hC0 + i, 0);
        repeat (40) @(negedge clk);
        n0 = accepts;
        in_valid = 1; in_addr = 32'd7777; in_data = 32'hDD;
        repeat (60) @(negedge clk);
        chk(accepts == n0, "R8", "writes taken while full", accepts - n0, 0);
        chk(in_ready == 0, "R8", "in_ready stalled", longint'(in_ready), 0);
        chk(rsp_valid == 1 && rsp_len == 0, "R7", "head response", longint'(rsp_len), 0);
        rsp_en = 1;
        do @(posedge clk); while (!acc_now);
        @(negedge clk); in_valid = 0;
        drain();
        chk(aw_log.size() == 5, "R7", "one response per burst", aw_log.size(), 5);
        aw_log.delete();

        // R6 R7 R9: mixed pattern with back-pressure everywhere.
        jit = 1;
        a = 32'd5000;
        for (int i = 0; i < 60; i++) begin
            a = (i % 11 == 10) ? 32'd9000 + 32'(i * 7) : a + 1;
            send(a, 32'hE000 + i, $urandom_range(0, 10));
        end
        drain();
        jit = 0;
        chk(ref_data.size() == 0, "R6", "beats left over", ref_data.size(), 0);
        chk(exp_rsp.size() == 0, "R7", "responses left over", exp_rsp.size(), 0);
        summary();
    end
endmodule